// File: doc/BRIEF.md
# I2C Master Byte Transmitter with Per-Byte Wait

The block is the transmit engine of an I2C master. The host first places the address byte in the shift register and issues a start command. The engine then puts a START on the bus, clocks the byte out most significant bit first, and releases SDA for the ninth (acknowledge) clock. When that clock ends, the engine parks with SCL driven low and pulses its interrupt. It does this whether the slave acknowledged or not. It also latches the acknowledge result in a status flag.

While parked, the engine waits for the host. A host write loads the next byte, clears the acknowledge flag and resumes clocking. A stop command instead produces a STOP condition and returns the engine to idle. SCL and SDA are open-drain: the outputs are "drive low" enables, and the inputs read the wired bus lines. Each SCL low phase and high phase lasts a programmable number of system clocks. A high phase is counted only while SCL actually reads high, so a slave that stretches the clock delays the engine.

States: IDLE, START (SDA pulled low while SCL is high), BIT_LO and BIT_HI (the data bits), ACK_LO and ACK_HI (the ninth clock), PARK (the wait), STOP_LO, STOP_HI and STOP_REL (the stop sequence).

Transitions:
- IDLE to START on a start command.
- START to BIT_LO when the hold time expires.
- BIT_LO to BIT_HI when the low time expires.
- BIT_HI to BIT_LO, or to ACK_LO after the eighth bit, when the high time expires.
- ACK_LO to ACK_HI, then ACK_HI to PARK.
- PARK to STOP_LO on a stop command.
- PARK to BIT_LO on a write.
- STOP_LO to STOP_HI, then STOP_HI to STOP_REL, then STOP_REL to IDLE.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset `scl_drive_low`, `sda_drive_low`, `irq`, `ack_seen` and `busy` are all 0.
- R2: A start command in IDLE pulls SDA low while SCL is released and high. Only after that is SCL driven low for the first bit. `busy` is 1 from START until the return to IDLE.
- R3: Bits leave MSB first. A 1 releases SDA and a 0 drives it low. SDA changes only while SCL is low, except for the START and STOP edges.
- R4: A low phase lasts max(`div_lo`,2) clocks. A high phase lasts max(`div_hi`,2) clocks, counted only while `scl_in` reads 1. Counting restarts whenever `scl_in` reads 0, so slave stretching lengthens the low time.
- R5: SDA is released for the ninth clock. `ack_seen` becomes 1 if `sda_in` is 0 in the last cycle of that high phase, and 0 otherwise.
- R6: At the end of the ninth clock, `irq` pulses for exactly one cycle while SCL is driven low. This happens for both ACK and NACK.
- R7: In PARK, SCL stays low for as long as neither a write nor a stop arrives. A write loads the byte, clears `ack_seen` in the next cycle and restarts clocking.
- R8: A host write in any state other than IDLE or PARK is ignored. The byte on the bus is unchanged.
- R9: A stop command in PARK drives SDA low while SCL is low, then releases SCL. After a high phase it releases SDA while SCL is high, and the engine returns to IDLE. If a stop and a write arrive in the same PARK cycle, the stop wins: the write is discarded and `ack_seen` keeps its value.
- R10: A stop command in IDLE and a start command outside IDLE have no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi | input | 16 | SCL high-phase length in clocks (minimum 2) |
| div_lo | input | 16 | SCL low-phase length in clocks (minimum 2) |
| host_wr | input | 1 | Write strobe for the shift register |
| host_wdata | input | 8 | Byte to transmit |
| cmd_start | input | 1 | Start command (accepted in IDLE) |
| cmd_stop | input | 1 | Stop command (accepted in PARK) |
| scl_in | input | 1 | Wired SCL line level |
| sda_in | input | 1 | Wired SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| ack_seen | output | 1 | Acknowledge detected on the last ninth clock |
| irq | output | 1 | One-cycle end-of-byte pulse |
| busy | output | 1 | Engine not in IDLE |

## Verification
Two functions can land in the same park cycle: the host write that releases the wait, and the stop command. The bench raises both strobes on one clock edge while `ack_seen` is 1. It then judges the result on the wire and at the flag. The bus must show a STOP and no further decoded byte, and `ack_seen` must keep its value. A second overlap is a slave stretch that begins inside the acknowledge low phase. It is judged by the measured low time, the unchanged high time and a correct acknowledge result.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_PARK,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_STOP_REL
    } txm_state_e;

    // States whose length is counted against SCL actually reading high
    function automatic logic is_high_phase(txm_state_e s);
        return (s inside {ST_START, ST_BIT_HI, ST_ACK_HI, ST_STOP_HI, ST_STOP_REL});
    endfunction

    // States whose length is a plain low-time count
    function automatic logic is_low_phase(txm_state_e s);
        return (s inside {ST_BIT_LO, ST_ACK_LO, ST_STOP_LO});
    endfunction

    // States in which the engine drives SCL low
    function automatic logic holds_scl_low(txm_state_e s);
        return (s inside {ST_BIT_LO, ST_ACK_LO, ST_PARK, ST_STOP_LO});
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_eff;

    assign lim_eff = (limit < MIN_LIM) ? MIN_LIM : limit;
    // ">=" keeps a limit lowered mid-phase from running the counter around
    assign expired = run && !clear && (cnt >= (lim_eff - ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || expired) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/i2c_tx_shifter.sv
module i2c_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              msb,
    output logic              last_bit
);
    localparam int               IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] sreg;
    logic [IDX_W-1:0]  idx;

    assign msb      = sreg[DATA_W-1];
    assign last_bit = (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= load_data;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {sreg[DATA_W-2:0], 1'b0};
            idx  <= last_bit ? '0 : idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
    import i2c_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_hi,
    input  logic [DIV_W-1:0]  div_lo,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              ack_seen,
    output logic              irq,
    output logic              busy
);

    txm_state_e state, nxt;

    logic             in_high, in_low;
    logic             tmr_run, tmr_clear, tmr_expired;
    logic [DIV_W-1:0] tmr_limit;
    logic             wr_accept, shift_en;
    logic             tx_msb, tx_last;
    logic             scl_q, sda_q, irq_q, ack_q;

    assign in_high   = is_high_phase(state);
    assign in_low    = is_low_phase(state);
    assign tmr_run   = in_high || in_low;
    assign tmr_clear = in_high && !scl_in;
    assign tmr_limit = in_high ? div_hi : div_lo;

    // Stop has priority over a write arriving in the same park cycle
    assign wr_accept = host_wr &&
                       ((state == ST_IDLE) || ((state == ST_PARK) && !cmd_stop));
    assign shift_en  = (state == ST_BIT_HI) && tmr_expired;

    i2c_phase_timer #(.CNT_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .clear   (tmr_clear),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    i2c_tx_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_accept),
        .load_data (host_wdata),
        .shift     (shift_en),
        .msb       (tx_msb),
        .last_bit  (tx_last)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (cmd_start)   nxt = ST_START;
            ST_START:    if (tmr_expired) nxt = ST_BIT_LO;
            ST_BIT_LO:   if (tmr_expired) nxt = ST_BIT_HI;
            ST_BIT_HI:   if (tmr_expired) nxt = tx_last ? ST_ACK_LO : ST_BIT_LO;
            ST_ACK_LO:   if (tmr_expired) nxt = ST_ACK_HI;
            ST_ACK_HI:   if (tmr_expired) nxt = ST_PARK;
            ST_PARK: begin
                if (cmd_stop)     nxt = ST_STOP_LO;
                else if (host_wr) nxt = ST_BIT_LO;
            end
            ST_STOP_LO:  if (tmr_expired) nxt = ST_STOP_HI;
            ST_STOP_HI:  if (tmr_expired) nxt = ST_STOP_REL;
            ST_STOP_REL: if (tmr_expired) nxt = ST_IDLE;
            default:                      nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b0;
            sda_q <= 1'b0;
            irq_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            scl_q <= holds_scl_low(nxt);
            irq_q <= (state == ST_ACK_HI) && tmr_expired;

            if ((state == ST_ACK_HI) && tmr_expired) ack_q <= !sda_in;
            else if (wr_accept)                      ack_q <= 1'b0;

            // SDA is updated from the current state, one cycle after SCL falls
            unique case (state)
                ST_IDLE:     sda_q <= 1'b0;
                ST_START:    sda_q <= 1'b1;
                ST_BIT_LO:   sda_q <= !tx_msb;
                ST_ACK_LO:   sda_q <= 1'b0;
                ST_STOP_LO:  sda_q <= 1'b1;
                ST_STOP_REL: sda_q <= 1'b0;
                default:     sda_q <= sda_q;
            endcase
        end
    end

    assign scl_drive_low = scl_q;
    assign sda_drive_low = sda_q;
    assign irq           = irq_q;
    assign ack_seen      = ack_q;
    assign busy          = (state != ST_IDLE);

    // Checks kept next to the logic they guard
    AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && $past(!scl_drive_low) &&
         (state inside {ST_BIT_HI, ST_ACK_HI, ST_STOP_HI})) |-> $stable(sda_drive_low)); // R3

    AST_HIGH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_high && tmr_expired) |-> scl_in); // R4

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_IN_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((state == ST_PARK) && scl_drive_low)); // R6

    AST_PARK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PARK) && !host_wr && !cmd_stop) |=> ((state == ST_PARK) && scl_drive_low)); // R7

    AST_ACK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PARK) && host_wr && !cmd_stop) |=> !ack_seen); // R7

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PARK) && cmd_stop) |=> ((state == ST_STOP_LO) && $stable(ack_seen))); // R9

endmodule

// File: tb/test_i2c_tx_master.sv
`timescale 1ns/1ps
module test_i2c_tx_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_hi = 16'd4;
    logic [15:0] div_lo = 16'd3;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        scl_drive_low, sda_drive_low, ack_seen, irq, busy;
    logic        slave_stretch = 1'b0;
    logic        ack_en = 1'b1;
    logic        slave_pull;
    logic        scl_line, sda_line;

    int n_cmp = 0;
    int n_err = 0;

    // Bus monitor state
    int   bitn = 0;
    int   n_start = 0, n_stop = 0, n_rise = 0, n_byte = 0, n_irq = 0, n_wide = 0;
    int   last_low = 0, last_high = 0, low_run = 0, high_run = 0;
    logic p_scl = 1'b1, p_sda = 1'b1, p_irq = 1'b0, samp = 1'b0, skip_fall = 1'b0;
    logic [7:0] sh = 8'h00, rx_byte = 8'h00;

    always #2 clk = ~clk;

    assign slave_pull = ack_en && (bitn == 8);
    assign scl_line   = !scl_drive_low && !slave_stretch;
    assign sda_line   = !sda_drive_low && !slave_pull;

    i2c_tx_master i_i2c_tx_master (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_hi        (div_hi),
        .div_lo        (div_lo),
        .host_wr       (host_wr),
        .host_wdata    (host_wdata),
        .cmd_start     (cmd_start),
        .cmd_stop      (cmd_stop),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .ack_seen      (ack_seen),
        .irq           (irq),
        .busy          (busy)
    );

    // Decodes the wired bus: START/STOP, bits, bytes, phase lengths
    always @(posedge clk) begin
        if (!rst_n) begin
            p_scl = 1'b1; p_sda = 1'b1; p_irq = 1'b0;
            bitn = 0; skip_fall = 1'b0;
        end else begin
            if (p_scl && scl_line && p_sda && !sda_line) begin
                n_start++; bitn = 0; skip_fall = 1'b1;
            end
            if (p_scl && scl_line && !p_sda && sda_line) n_stop++;
            if (scl_line) begin
                if (!p_scl) begin
                    last_low = low_run; samp = sda_line; high_run = 1; n_rise++;
                end else high_run++;
            end else begin
                if (p_scl) begin
                    last_high = high_run; low_run = 1;
                    if (skip_fall) skip_fall = 1'b0;
                    else begin
                        if (bitn < 8) sh = {sh[6:0], samp};
                        else begin rx_byte = sh; n_byte++; end
                        bitn = (bitn == 8) ? 0 : bitn + 1;
                    end
                end else low_run++;
            end
            if (irq) begin n_irq++; if (p_irq) n_wide++; end
            p_irq = irq;
            p_scl = scl_line; p_sda = sda_line;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic do_write(input logic [7:0] b);
        @(negedge clk); host_wr = 1'b1; host_wdata = b;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
    endtask

    // Waits for the end-of-byte pulse; reports flag and SCL drive seen with it
    task automatic wait_irq(input string req, output logic a, output logic s);
        int n = 0;
        a = 1'bx; s = 1'bx;
        @(negedge clk);
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        chk(req, "irq arrives", int'(irq), 1);
        a = ack_seen; s = scl_drive_low;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk(req, "return to idle", int'(busy), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1", "scl_drive_low", int'(scl_drive_low), 0);
        chk("R1", "sda_drive_low", int'(sda_drive_low), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "ack_seen", int'(ack_seen), 0);
        chk("R1", "busy", int'(busy), 0);
    endtask

    task automatic t_ack_stream();
        int s0 = n_start, p0 = n_stop, q0 = n_irq;
        logic a, s;
        ack_en = 1'b1;
        do_write(8'hA4);
        do_start();
        chk("R2", "busy after start", int'(busy), 1);
        wait_irq("R6", a, s);
        chk("R2", "one START seen", n_start - s0, 1);
        chk("R3", "address byte", int'(rx_byte), 8'hA4);
        chk("R5", "ack_seen on ACK", int'(a), 1);
        chk("R6", "SCL held low at irq", int'(s), 1);
        chk("R4", "ack high length", last_high, 4);
        chk("R4", "ack low length", last_low, 3);
        do_write(8'h5A);
        wait_irq("R6", a, s);
        chk("R3", "data byte 5A", int'(rx_byte), 8'h5A);
        do_write(8'h81);
        wait_irq("R6", a, s);
        chk("R3", "data byte 81", int'(rx_byte), 8'h81);
        chk("R6", "irq count", n_irq - q0, 3);
        chk("R6", "irq width", n_wide, 0);
        do_stop();
        wait_idle("R9");
        chk("R9", "one STOP seen", n_stop - p0, 1);
        chk("R3", "no stray START", n_start - s0, 1);
        chk("R9", "SDA released", int'(sda_drive_low), 0);
        chk("R9", "SCL released", int'(scl_drive_low), 0);
    endtask

    task automatic t_nack_address();
        int p0 = n_stop, q0 = n_irq;
        logic a, s;
        ack_en = 1'b0;
        do_write(8'h3B);
        do_start();
        wait_irq("R6", a, s);
        chk("R5", "ack_seen on NACK", int'(a), 0);
        chk("R6", "irq on NACK", n_irq - q0, 1);
        chk("R3", "nacked address byte", int'(rx_byte), 8'h3B);
        ack_en = 1'b1;
        do_stop();
        wait_idle("R9");
        chk("R9", "STOP after NACK", n_stop - p0, 1);
    endtask

    task automatic t_park_hold();
        int rc;
        logic a, s;
        do_write(8'h10);
        do_start();
        wait_irq("R6", a, s);
        chk("R5", "ack before park", int'(a), 1);
        rc = n_rise;
        repeat (300) @(negedge clk);
        chk("R7", "no SCL edge while parked", n_rise - rc, 0);
        chk("R7", "SCL still low", int'(scl_drive_low), 1);
        chk("R7", "busy while parked", int'(busy), 1);
        do_write(8'h22);
        chk("R7", "ack_seen cleared by write", int'(ack_seen), 0);
        wait_irq("R7", a, s);
        chk("R7", "byte after release", int'(rx_byte), 8'h22);
    endtask

    task automatic t_write_ignored();
        logic a, s;
        do_write(8'hC3);
        repeat (12) @(negedge clk);
        do_write(8'hFF);
        wait_irq("R8", a, s);
        chk("R8", "mid-byte write ignored", int'(rx_byte), 8'hC3);
    endtask

    task automatic t_stop_beats_write();
        int s0 = n_start, p0 = n_stop, b0 = n_byte;
        chk("R9", "ack_seen set before collision", int'(ack_seen), 1);
        @(negedge clk); host_wr = 1'b1; host_wdata = 8'h00; cmd_stop = 1'b1;
        @(negedge clk); host_wr = 1'b0; cmd_stop = 1'b0;
        chk("R9", "ack_seen kept on collision", int'(ack_seen), 1);
        wait_idle("R9");
        chk("R9", "STOP on collision", n_stop - p0, 1);
        chk("R9", "no byte after collision", n_byte - b0, 0);
        chk("R9", "no START on collision", n_start - s0, 0);
    endtask

    task automatic t_stretch_and_clamp();
        int n = 0;
        logic a, s;
        do_write(8'h96);
        do_start();
        while (bitn != 8 && n < 5000) begin @(negedge clk); n++; end
        slave_stretch = 1'b1;
        repeat (10) @(negedge clk);
        slave_stretch = 1'b0;
        wait_irq("R4", a, s);
        chk_rng("R4", "stretched low length", last_low, 10, 13);
        chk("R4", "high length after stretch", last_high, 4);
        chk("R5", "ack through stretch", int'(a), 1);
        chk("R3", "byte through stretch", int'(rx_byte), 8'h96);
        div_hi = 16'd1; div_lo = 16'd1;
        do_write(8'h0F);
        wait_irq("R4", a, s);
        chk("R4", "clamped high length", last_high, 2);
        chk("R4", "clamped low length", last_low, 2);
        chk("R3", "byte at minimum divider", int'(rx_byte), 8'h0F);
        div_hi = 16'd4; div_lo = 16'd3;
        do_stop();
        wait_idle("R9");
    endtask

    task automatic t_idle_commands();
        int s0 = n_start, p0 = n_stop, r0 = n_rise;
        logic a, s;
        do_stop();
        repeat (20) @(negedge clk);
        chk("R10", "stop in idle: busy", int'(busy), 0);
        chk("R10", "stop in idle: no STOP", n_stop - p0, 0);
        chk("R10", "stop in idle: no SCL edge", n_rise - r0, 0);
        chk("R10", "stop in idle: SDA free", int'(sda_drive_low), 0);
        do_write(8'h55);
        do_start();
        repeat (20) @(negedge clk);
        do_start();
        wait_irq("R10", a, s);
        chk("R10", "start while busy ignored", n_start - s0, 1);
        chk("R10", "byte unaffected", int'(rx_byte), 8'h55);
        do_stop();
        wait_idle("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_err++;
        $display("FAIL watchdog: actual=150000 cycles expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_ack_stream();
        t_nack_address();
        t_park_hold();
        t_write_ignored();
        t_stop_beats_write();
        t_stretch_and_clamp();
        t_idle_commands();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule